// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides where each of the two execute-stage ALU operands of a five-stage in-order integer pipeline comes from. An instruction that reads a register written by one of the two instructions ahead of it would otherwise see the stale register-file copy. The selector compares the instruction's two source register numbers with the destinations of the instructions in the memory and write-back stages. For each operand it emits a 2-bit code that picks the register-file value, the ALU result one stage ahead, or the write-back data two stages ahead.

The top level is a thin registered harness around the selector. It holds the decode/execute, execute/memory and memory/write-back pipeline fields. It also drives the two operand multiplexers, so that the forwarded operand values appear at the ports in the cycle the instruction sits in execute. The instruction enters the decode/execute register on the clock edge that samples the `dec_*` inputs. On the same edge, `ex_alu_res`, the result of the instruction leaving execute, is captured into the execute/memory register. The write-back data is that result one stage later.

Top module: `bypass_unit`

## Requirements
- R1: With no qualifying match, a select code is 00 and the operand equals the register-file value that was captured with the instruction.
- R2: Operand A select is 10 when the instruction one ahead writes a register (write flag 1), its destination is nonzero, and that destination equals source A.
- R3: Operand B select is 10 under the same condition, compared with source B.
- R4: A select is 01 when the instruction two ahead writes a nonzero destination equal to that operand's source, and R2/R3 does not hold for that operand.
- R5: When both older instructions match the same source, the code is 10, so the newer value wins.
- R6: A destination of register 0 never forwards. An operand whose source is register 0 is always code 00.
- R7: An older instruction whose write flag is 0 never forwards, even when its destination matches. It also does not block a match two ahead.
- R8: Code 10 delivers the ALU result presented on `ex_alu_res` one clock earlier. Code 01 delivers the result presented two clocks earlier.
- R9: After reset both select codes are 00 and both operands are 0.
- R10: Each clock moves the destination and write flag from decode/execute to execute/memory, and from there to memory/write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_rs | input | 5 | Source A register number of the decoded instruction |
| dec_rt | input | 5 | Source B register number of the decoded instruction |
| dec_rd | input | 5 | Destination register number of the decoded instruction |
| dec_wen | input | 1 | Decoded instruction writes its destination |
| dec_a | input | 32 | Register-file value read for source A |
| dec_b | input | 32 | Register-file value read for source B |
| ex_alu_res | input | 32 | ALU result of the instruction currently in execute |
| sel_a | output | 2 | Operand A select (00 register file, 10 one ahead, 01 two ahead) |
| sel_b | output | 2 | Operand B select, same encoding |
| op_a | output | 32 | Forwarded operand A |
| op_b | output | 32 | Forwarded operand B |

## Verification
The bench replays a subtract whose result feeds three later instructions at distances one, two and three. A selector that ignored a match would hand the and/or instructions the old value 10 instead of -20. A run of three adds to the same register checks the priority case; a design that preferred the older stage would return the sum one step behind. Writes to register 0 and instructions with a cleared write flag are followed by readers of those registers. A design missing the zero or write-flag test would forward a nonzero or unwritten value. A design that blocked the older match with the raw destination compare would fall back to the stale register-file value.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int N_OPS  = 2;

    typedef logic [REG_W-1:0]  regid_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_REG = 2'b00,
        SEL_WB  = 2'b01,
        SEL_ALU = 2'b10
    } opsel_e;

    typedef struct packed {
        regid_t rs;
        regid_t rt;
        regid_t rd;
        logic   wen;
        word_t  a;
        word_t  b;
    } idex_t;

    typedef struct packed {
        regid_t rd;
        logic   wen;
        word_t  res;
    } stage_t;

    typedef struct packed {
        idex_t  idex;
        stage_t exmem;
        stage_t memwb;
    } pipe_t;
endpackage

// File: rtl/bypass_pick.sv
module bypass_pick
    import bypass_pkg::*;
(
    input  regid_t src,
    input  logic   ex_wen,
    input  regid_t ex_rd,
    input  logic   wb_wen,
    input  regid_t wb_rd,
    output opsel_e sel
);
    logic ex_hit;
    logic wb_hit;

    always_comb begin
        ex_hit = ex_wen && (ex_rd != '0) && (ex_rd == src);
        wb_hit = wb_wen && (wb_rd != '0) && (wb_rd == src);
        if (ex_hit)      sel = SEL_ALU;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_REG;
    end
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
    import bypass_pkg::*;
(
    input  regid_t src    [N_OPS],
    input  logic   ex_wen,
    input  regid_t ex_rd,
    input  logic   wb_wen,
    input  regid_t wb_rd,
    output opsel_e sel    [N_OPS]
);
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        bypass_pick i_pick (
            .src    (src[g]),
            .ex_wen (ex_wen),
            .ex_rd  (ex_rd),
            .wb_wen (wb_wen),
            .wb_rd  (wb_rd),
            .sel    (sel[g])
        );
    end
endmodule

// File: rtl/operand_mux.sv
module operand_mux
    import bypass_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  opsel_e         sel,
    input  logic [W-1:0]   rf_val,
    input  logic [W-1:0]   alu_val,
    input  logic [W-1:0]   wb_val,
    output logic [W-1:0]   out
);
    always_comb begin
        case (sel)
            SEL_ALU: out = alu_val;
            SEL_WB:  out = wb_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/bypass_unit.sv
module bypass_unit
    import bypass_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  dec_rs,
    input  logic [4:0]  dec_rt,
    input  logic [4:0]  dec_rd,
    input  logic        dec_wen,
    input  logic [31:0] dec_a,
    input  logic [31:0] dec_b,
    input  logic [31:0] ex_alu_res,
    output logic [1:0]  sel_a,
    output logic [1:0]  sel_b,
    output logic [31:0] op_a,
    output logic [31:0] op_b
);
    pipe_t  pipe_d, pipe_q;
    regid_t srcs [N_OPS];
    opsel_e sels [N_OPS];
    word_t  rf_vals [N_OPS];
    word_t  ops  [N_OPS];

    always_comb begin
        pipe_d              = pipe_q;
        pipe_d.idex.rs      = dec_rs;
        pipe_d.idex.rt      = dec_rt;
        pipe_d.idex.rd      = dec_rd;
        pipe_d.idex.wen     = dec_wen;
        pipe_d.idex.a       = dec_a;
        pipe_d.idex.b       = dec_b;
        pipe_d.exmem.rd     = pipe_q.idex.rd;
        pipe_d.exmem.wen    = pipe_q.idex.wen;
        pipe_d.exmem.res    = ex_alu_res;
        pipe_d.memwb        = pipe_q.exmem;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign srcs[0]    = pipe_q.idex.rs;
    assign srcs[1]    = pipe_q.idex.rt;
    assign rf_vals[0] = pipe_q.idex.a;
    assign rf_vals[1] = pipe_q.idex.b;

    bypass_ctrl i_ctrl (
        .src    (srcs),
        .ex_wen (pipe_q.exmem.wen),
        .ex_rd  (pipe_q.exmem.rd),
        .wb_wen (pipe_q.memwb.wen),
        .wb_rd  (pipe_q.memwb.rd),
        .sel    (sels)
    );

    for (genvar g = 0; g < N_OPS; g++) begin : g_mux
        operand_mux #(.W(DATA_W)) i_mux (
            .sel     (sels[g]),
            .rf_val  (rf_vals[g]),
            .alu_val (pipe_q.exmem.res),
            .wb_val  (pipe_q.memwb.res),
            .out     (ops[g])
        );
    end

    assign sel_a = sels[0];
    assign sel_b = sels[1];
    assign op_a  = ops[0];
    assign op_b  = ops[1];

    p_no_code11_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11));

    p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.idex.rs == '0) |-> (sel_a == SEL_REG));

    p_no_wen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_q.exmem.wen && !pipe_q.memwb.wen) |-> (sel_a == SEL_REG && sel_b == SEL_REG));

    p_alu_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == SEL_ALU) |-> (op_a == $past(ex_alu_res)));

    p_wb_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == SEL_WB) |-> (op_b == $past(ex_alu_res, 2)));

    p_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pipe_q.memwb.rd == $past(pipe_q.exmem.rd)
                  && pipe_q.exmem.wen == $past(pipe_q.idex.wen)));
endmodule

// File: tb/test_bypass_unit.sv
module test_bypass_unit;
    localparam int CLK_P = 10;

    typedef enum int {OP_ADD, OP_SUB, OP_AND, OP_OR} op_e;
    typedef struct {
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic [31:0] va;
        logic [31:0] vb;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dec_rs = '0, dec_rt = '0, dec_rd = '0;
    logic        dec_wen = 1'b0;
    logic [31:0] dec_a = '0, dec_b = '0, ex_alu_res = '0;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] op_a, op_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    exp_t        q[$];
    logic [31:0] arch [32];
    logic [31:0] rf   [32];
    logic        h_wen [1:3];
    logic [4:0]  h_rd  [1:3];
    logic [31:0] h_val [1:3];

    bypass_unit i_bypass_unit (
        .clk(clk), .rst_n(rst_n),
        .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_rd(dec_rd), .dec_wen(dec_wen),
        .dec_a(dec_a), .dec_b(dec_b), .ex_alu_res(ex_alu_res),
        .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(logic [4:0] src);
        if (h_wen[1] && h_rd[1] != 0 && h_rd[1] == src) return 2'b10;
        if (h_wen[2] && h_rd[2] != 0 && h_rd[2] == src) return 2'b01;
        return 2'b00;
    endfunction

    task automatic issue(op_e op, int rd, int rs, int rt, bit wen, string tag);
        exp_t e;
        logic [31:0] a, b, v;
        @(negedge clk);
        if (h_wen[3] && h_rd[3] != 0) rf[h_rd[3]] = h_val[3];
        a = arch[rs];
        b = arch[rt];
        case (op)
            OP_SUB:  v = a - b;
            OP_AND:  v = a & b;
            OP_OR:   v = a | b;
            default: v = a + b;
        endcase
        e.sa = exp_sel(5'(rs));
        e.sb = exp_sel(5'(rt));
        e.va = a;
        e.vb = b;
        e.tag = tag;
        dec_rs = 5'(rs); dec_rt = 5'(rt); dec_rd = 5'(rd); dec_wen = wen;
        dec_a = rf[rs]; dec_b = rf[rt];
        ex_alu_res = h_val[1];
        q.push_back(e);
        if (wen && rd != 0) arch[rd] = v;
        h_wen[3] = h_wen[2]; h_rd[3] = h_rd[2]; h_val[3] = h_val[2];
        h_wen[2] = h_wen[1]; h_rd[2] = h_rd[1]; h_val[2] = h_val[1];
        h_wen[1] = wen;      h_rd[1] = 5'(rd); h_val[1] = v;
    endtask

    task automatic bubble();
        issue(OP_ADD, 0, 0, 0, 1'b0, "R1");
    endtask

    always @(posedge clk) begin
        #(CLK_P/4);
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "sel_a", 32'(sel_a), 32'(e.sa));
            check(e.tag, "sel_b", 32'(sel_b), 32'(e.sb));
            check({e.tag, " R8 R10"}, "op_a", op_a, e.va);
            check({e.tag, " R8 R10"}, "op_b", op_b, e.vb);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            arch[i] = (i == 0) ? 32'd0 : 32'(i * 7 + 1);
        end
        arch[1] = 32'd3; arch[2] = 32'd10; arch[3] = 32'd23;
        for (int i = 0; i < 32; i++) rf[i] = arch[i];
        for (int i = 1; i <= 3; i++) begin
            h_wen[i] = 1'b0; h_rd[i] = '0; h_val[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R9", "sel_a reset", 32'(sel_a), 0);
        check("R9", "sel_b reset", 32'(sel_b), 0);
        check("R9", "op_a reset", op_a, 0);
        check("R9", "op_b reset", op_b, 0);

        // sub then dependents at distance 1, 2 and 3
        issue(OP_SUB, 2, 1, 3, 1'b1, "R1");
        issue(OP_AND, 12, 2, 5, 1'b1, "R2");
        issue(OP_OR, 13, 6, 2, 1'b1, "R4");
        issue(OP_ADD, 14, 2, 2, 1'b1, "R1");
        bubble(); bubble(); bubble();
        // same register written back to back: newer wins
        issue(OP_ADD, 1, 1, 2, 1'b1, "R2");
        issue(OP_ADD, 1, 1, 3, 1'b1, "R5");
        issue(OP_ADD, 1, 1, 4, 1'b1, "R5");
        issue(OP_ADD, 9, 4, 1, 1'b1, "R3");
        bubble(); bubble(); bubble();
        // writes to register zero must not forward
        issue(OP_ADD, 0, 1, 2, 1'b1, "R6");
        issue(OP_AND, 7, 0, 0, 1'b1, "R6");
        issue(OP_OR, 7, 0, 0, 1'b1, "R6");
        bubble(); bubble(); bubble();
        // write flag cleared: no forward, no blocking of the older match
        issue(OP_SUB, 8, 5, 6, 1'b1, "R1");
        issue(OP_ADD, 8, 8, 5, 1'b0, "R2");
        issue(OP_ADD, 10, 8, 8, 1'b1, "R7");
        issue(OP_ADD, 11, 5, 5, 1'b0, "R7");
        issue(OP_OR, 15, 11, 11, 1'b1, "R7");
        // operand B only, from the write-back stage
        issue(OP_ADD, 16, 4, 6, 1'b1, "R1");
        bubble();
        issue(OP_ADD, 17, 5, 16, 1'b1, "R4");
        bubble(); bubble(); bubble();
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule